// File: doc/BRIEF.md
# Dual-Output Cascaded Interrupt Controller

This block collects a wide vector of interrupt request lines (224 by default) and presents them to an upstream controller as two interrupt outputs. Every source can be set up independently as edge or level sensitive, active high or active low. It can be enabled or disabled, and it can be steered to either output. Edge events are held in a pending bit until software clears it. Level sources show their input state directly.

Software reaches the block over a plain 32-bit register port. A region select bit picks between two regions, and a 5-bit word index picks the word. Region 0 holds the configuration. Region 1 holds the clear strobes, the per-output masked-pending words and one summary word. The summary word tells an interrupt handler which 32-source groups hold work for each output, so the handler can go straight to the right masked-pending word.

Top module: `dual_route_intc`

## Requirements
- R1: After reset both outputs are low. Every type bit reads 1 (edge), every polarity bit reads 0, every routing bit reads 1 (output 0) and every enable bit reads 0.
- R2: Region select 0 holds four arrays, each one word per group of 32 sources: type at words 0-6, polarity at words 7-13, routing at words 14-20 and enable at words 21-27. Source n sits in word base+n/32, bit n%32. Read data appears on the cycle after the read strobe and is 0 on any cycle that follows no read strobe.
- R3: An edge-sensitive source sets its pending bit on a 0-to-1 change of its polarity-adjusted input. The bit stays set after the input returns to idle.
- R4: A polarity bit of 1 inverts the input, so an active-low level or a falling edge is detected. A rising edge of an inverted edge source sets nothing.
- R5: A level-sensitive source (type bit 0) has a pending bit that follows its polarity-adjusted input. A clear write has no lasting effect on it.
- R6: Writing region 1, words 0-6, clears the pending bit of each edge source whose data bit is 1. Data bits of 0 leave pending state unchanged. When a new edge and a clear land on the same cycle, the pending bit stays set.
- R7: A pending, enabled source with routing bit 1 drives output 0. With routing bit 0 it drives output 1, never both.
- R8: An enable bit of 0 keeps a source off both outputs and out of the masked-pending words. Its pending bit is still kept, so enabling the source later raises the output at once.
- R9: Region 1, words 7-13, read pending AND enable AND NOT routing (output 1). Words 14-20 read pending AND enable AND routing (output 0).
- R10: Region 1, word 31, bit g (0-6) is set when group g has an enabled pending source for output 1. Bit 8+g is set for output 0. All other bits read 0.
- R11: A change on a source input reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages plus the pending register.
- R12: Writes to region 1 words other than the clear words have no effect. Reads of the clear words return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_region_i | input | 1 | Region select: 0 configuration, 1 status/clear |
| bus_word_i | input | 5 | Word index within the region |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq0_o | output | 1 | Upstream interrupt output 0 |
| irq1_o | output | 1 | Upstream interrupt output 1 |

## Verification
Single sources are driven with short pulses and with held levels, in groups 0, 1, 3, 4 and 6. The pulse tests show that edge sources latch and level sources track. Pulses on an inverted source show that only the falling edge counts. Steering a source to output 1 and reading both masked-pending words and the summary word separates the routing paths from each other. A clear written on the same cycle as a new edge, a pulse on a disabled source that is enabled afterwards, and writes to read-only status words check the ordering and no-effect cases.

// File: rtl/dri_pkg.sv
`timescale 1ns/1ps
package dri_pkg;
   localparam int WORD_W       = 32;
   localparam int ADDR_W       = 5;
   localparam int MAX_GROUPS   = 8;
   localparam int SUM_WORD     = 31;
   localparam int SUM_OUT0_LSB = 8;
   localparam int NUM_ARRAYS   = 4;
   // configuration array order inside region 0
   localparam int ARR_TYPE  = 0;
   localparam int ARR_POL   = 1;
   localparam int ARR_ROUTE = 2;
   localparam int ARR_MASK  = 3;

   typedef enum logic {
      REGION_CFG  = 1'b0,
      REGION_STAT = 1'b1
   } region_e;
endpackage

// File: rtl/dri_sync.sv
`timescale 1ns/1ps
module dri_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dri_detect.sv
`timescale 1ns/1ps
module dri_detect #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level_i,
   input  logic [N-1:0] type_i,
   input  logic [N-1:0] pol_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] act;
   logic [N-1:0] prev_q;
   logic [N-1:0] rise;
   logic [N-1:0] pend_q;
   logic [N-1:0] pend_d;

   assign act  = level_i ^ pol_i;
   assign rise = act & ~prev_q;
   // edge sources: sticky, set beats clear; level sources: track input
   assign pend_d = (type_i & ((pend_q & ~clr_i) | rise)) | (~type_i & act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= act;
         pend_q <= pend_d;
      end
   end

   assign pend_o = pend_q;

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_q & type_i & ~clr_i) & type_i & ~pend_q) == '0)); // R3

   AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr_i & type_i & ~rise) & type_i & pend_q) == '0)); // R6

   AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(~type_i) & ~type_i & (pend_q ^ $past(act))) == '0)); // R5
endmodule

// File: rtl/dri_regs.sv
`timescale 1ns/1ps
module dri_regs
   import dri_pkg::*;
#(
   parameter int NUM_GRP = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_i,
   input  logic                      rd_i,
   input  logic                      region_i,
   input  logic [ADDR_W-1:0]         word_i,
   input  logic [WORD_W-1:0]         wdata_i,
   input  logic [NUM_GRP*WORD_W-1:0] mp0_i,
   input  logic [NUM_GRP*WORD_W-1:0] mp1_i,
   input  logic [WORD_W-1:0]         summary_i,
   output logic [NUM_GRP*WORD_W-1:0] type_o,
   output logic [NUM_GRP*WORD_W-1:0] pol_o,
   output logic [NUM_GRP*WORD_W-1:0] route_o,
   output logic [NUM_GRP*WORD_W-1:0] mask_o,
   output logic [NUM_GRP*WORD_W-1:0] clr_o,
   output logic [WORD_W-1:0]         rdata_o
);
   localparam int CLR_BASE = 0;
   localparam int MP1_BASE = NUM_GRP;
   localparam int MP0_BASE = 2 * NUM_GRP;

   logic [NUM_ARRAYS-1:0][NUM_GRP-1:0][WORD_W-1:0] cfg_q;
   logic [WORD_W-1:0] rd_word;
   logic [WORD_W-1:0] rdata_q;
   logic              cfg_sel;
   logic              stat_sel;

   assign cfg_sel  = (region_i == REGION_CFG);
   assign stat_sel = (region_i == REGION_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARRAYS; a++) begin
            for (int g = 0; g < NUM_GRP; g++) begin
               cfg_q[a][g] <= (a == ARR_TYPE || a == ARR_ROUTE) ?
                              {WORD_W{1'b1}} : {WORD_W{1'b0}};
            end
         end
      end else if (wr_i && cfg_sel) begin
         for (int a = 0; a < NUM_ARRAYS; a++) begin
            for (int g = 0; g < NUM_GRP; g++) begin
               if (word_i == ADDR_W'(a * NUM_GRP + g)) cfg_q[a][g] <= wdata_i;
            end
         end
      end
   end

   assign type_o  = cfg_q[ARR_TYPE];
   assign pol_o   = cfg_q[ARR_POL];
   assign route_o = cfg_q[ARR_ROUTE];
   assign mask_o  = cfg_q[ARR_MASK];

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_clr
         assign clr_o[g*WORD_W +: WORD_W] =
            (wr_i && stat_sel && word_i == ADDR_W'(CLR_BASE + g)) ? wdata_i : '0;
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      if (cfg_sel) begin
         for (int a = 0; a < NUM_ARRAYS; a++) begin
            for (int g = 0; g < NUM_GRP; g++) begin
               if (word_i == ADDR_W'(a * NUM_GRP + g)) rd_word = cfg_q[a][g];
            end
         end
      end else begin
         for (int g = 0; g < NUM_GRP; g++) begin
            if (word_i == ADDR_W'(MP1_BASE + g)) rd_word = mp1_i[g*WORD_W +: WORD_W];
            if (word_i == ADDR_W'(MP0_BASE + g)) rd_word = mp0_i[g*WORD_W +: WORD_W];
         end
         if (word_i == ADDR_W'(SUM_WORD)) rd_word = summary_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_i ? rd_word : '0;
   end

   assign rdata_o = rdata_q;

   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> (rdata_o == '0)); // R2

   AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o != '0) |-> (wr_i && stat_sel)); // R12
endmodule

// File: rtl/dual_route_intc.sv
`timescale 1ns/1ps
module dual_route_intc
   import dri_pkg::*;
#(
   parameter int NUM_SRC     = 224,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   input  logic               bus_region_i,
   input  logic [4:0]         bus_word_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   output logic               irq0_o,
   output logic               irq1_o
);
   localparam int NUM_GRP = NUM_SRC / WORD_W;

   generate
      if (NUM_SRC % WORD_W != 0) begin : g_chk_width
         $error("NUM_SRC must be a multiple of the word width");
      end
      if (NUM_GRP < 1 || NUM_GRP > MAX_GROUPS) begin : g_chk_groups
         $error("NUM_SRC gives an unsupported number of groups");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_chk_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_sync;
   logic [NUM_SRC-1:0] cfg_type;
   logic [NUM_SRC-1:0] cfg_pol;
   logic [NUM_SRC-1:0] cfg_route;
   logic [NUM_SRC-1:0] cfg_mask;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mp0;
   logic [NUM_SRC-1:0] mp1;
   logic [WORD_W-1:0]  summary;

   dri_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_sync)
   );

   dri_detect #(.N(NUM_SRC)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (src_sync),
      .type_i  (cfg_type),
      .pol_i   (cfg_pol),
      .clr_i   (clr_vec),
      .pend_o  (pend)
   );

   assign mp0 = pend & cfg_mask & cfg_route;
   assign mp1 = pend & cfg_mask & ~cfg_route;

   generate
      for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_sum
         if (g < NUM_GRP) begin : g_used
            assign summary[g]                = |mp1[g*WORD_W +: WORD_W];
            assign summary[SUM_OUT0_LSB + g] = |mp0[g*WORD_W +: WORD_W];
         end else begin : g_unused
            assign summary[g]                = 1'b0;
            assign summary[SUM_OUT0_LSB + g] = 1'b0;
         end
      end
   endgenerate
   assign summary[WORD_W-1:SUM_OUT0_LSB+MAX_GROUPS] = '0;

   dri_regs #(.NUM_GRP(NUM_GRP)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr_i),
      .rd_i      (bus_rd_i),
      .region_i  (bus_region_i),
      .word_i    (bus_word_i),
      .wdata_i   (bus_wdata_i),
      .mp0_i     (mp0),
      .mp1_i     (mp1),
      .summary_i (summary),
      .type_o    (cfg_type),
      .pol_o     (cfg_pol),
      .route_o   (cfg_route),
      .mask_o    (cfg_mask),
      .clr_o     (clr_vec),
      .rdata_o   (bus_rdata_o)
   );

   assign irq0_o = |mp0;
   assign irq1_o = |mp1;

   AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask == '0) |-> (!irq0_o && !irq1_o)); // R8

   AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ((mp0 & mp1) == '0)); // R7

   AST_SUM_OUT0: assert property (@(posedge clk) disable iff (!rst_n)
      irq0_o == (|summary[SUM_OUT0_LSB +: MAX_GROUPS])); // R10

   AST_SUM_OUT1: assert property (@(posedge clk) disable iff (!rst_n)
      irq1_o == (|summary[MAX_GROUPS-1:0])); // R10
endmodule

// File: tb/tb_dual_route_intc.sv
`timescale 1ns/1ps
module tb_dual_route_intc;
   localparam int NSRC = 224;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n;
   logic [NSRC-1:0] src;
   logic            wr, rd, region;
   logic [4:0]      word;
   logic [31:0]     wdata;
   logic [31:0]     rdata;
   logic            irq0, irq1;

   dual_route_intc #(.NUM_SRC(NSRC)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_i        (src),
      .bus_wr_i     (wr),
      .bus_rd_i     (rd),
      .bus_region_i (region),
      .bus_word_i   (word),
      .bus_wdata_i  (wdata),
      .bus_rdata_o  (rdata),
      .irq0_o       (irq0),
      .irq1_o       (irq1)
   );

   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   // scoreboard monitor: read data is due one edge after the strobe
   always @(posedge clk) rd_seen <= rd;

   always @(negedge clk) begin : monitor
      logic [31:0] e;
      string       t;
      if (rd_seen === 1'b1) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: read data %h with nothing expected", rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic wr_reg(input logic r, input int w, input logic [31:0] d);
      @(negedge clk);
      region = r; word = w[4:0]; wdata = d; wr = 1'b1;
      @(posedge clk);
      #1 wr = 1'b0;
   endtask

   task automatic rd_reg(input logic r, input int w, input logic [31:0] e, input string t);
      @(negedge clk);
      region = r; word = w[4:0]; rd = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk);
      #1 rd = 1'b0;
   endtask

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", t, act, e);
      end
   endtask

   task automatic chk_irq(input string t, input logic e0, input logic e1);
      chk({t, " irq0"}, {31'b0, irq0}, {31'b0, e0});
      chk({t, " irq1"}, {31'b0, irq1}, {31'b0, e1});
   endtask

   task automatic set_src(input int idx, input logic v);
      @(negedge clk);
      src[idx] = v;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; src = '0; wr = 1'b0; rd = 1'b0;
      region = 1'b0; word = '0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk_irq("R1 reset", 1'b0, 1'b0);
      rd_reg(1'b0, 0,  32'hFFFF_FFFF, "R1 type reset");
      rd_reg(1'b0, 7,  32'h0,         "R1 polarity reset");
      rd_reg(1'b0, 14, 32'hFFFF_FFFF, "R1 routing reset");
      rd_reg(1'b0, 21, 32'h0,         "R1 enable reset");
      rd_reg(1'b1, 31, 32'h0,         "R10 summary idle");
      @(negedge clk);
      chk("R2 rdata idle", rdata, 32'h0);

      // enable sources 5 (group 0) and 200 (group 6)
      wr_reg(1'b0, 21, 32'h0000_0020);
      wr_reg(1'b0, 27, 32'h0000_0100);

      // R11 latency and R3 latch, source 5 to output 0
      set_src(5, 1'b1);
      @(posedge clk); @(posedge clk); #1;
      chk_irq("R11 before third edge", 1'b0, 1'b0);
      @(posedge clk); #1;
      chk_irq("R11 at third edge", 1'b1, 1'b0);
      set_src(5, 1'b0);
      settle();
      chk_irq("R3 edge held", 1'b1, 1'b0);
      rd_reg(1'b1, 14, 32'h0000_0020, "R9 out0 masked pending");
      rd_reg(1'b1, 31, 32'h0000_0100, "R10 summary out0 group0");

      // R6 clear behaviour
      wr_reg(1'b1, 0, 32'h0000_0000);
      #1 chk_irq("R6 zero write no effect", 1'b1, 1'b0);
      wr_reg(1'b1, 0, 32'h0000_0020);
      #1 chk_irq("R6 clear", 1'b0, 1'b0);

      // R7 route source 200 to output 1
      wr_reg(1'b0, 20, 32'hFFFF_FEFF);
      set_src(200, 1'b1);
      settle();
      chk_irq("R7 routed to out1", 1'b0, 1'b1);
      set_src(200, 1'b0);
      rd_reg(1'b1, 13, 32'h0000_0100, "R9 out1 masked pending");
      rd_reg(1'b1, 20, 32'h0000_0000, "R9 out0 word group6");
      rd_reg(1'b1, 31, 32'h0000_0040, "R10 summary out1 group6");
      wr_reg(1'b1, 6, 32'h0000_0100);
      #1 chk_irq("R6 clear group6", 1'b0, 1'b0);

      // R4 inverted edge, source 40 (group 1 bit 8)
      wr_reg(1'b0, 8, 32'h0000_0100);
      repeat (4) @(posedge clk);
      wr_reg(1'b1, 1, 32'h0000_0100);
      wr_reg(1'b0, 22, 32'h0000_0100);
      #1 chk_irq("R4 after setup", 1'b0, 1'b0);
      set_src(40, 1'b1);
      settle();
      chk_irq("R4 rising ignored", 1'b0, 1'b0);
      set_src(40, 1'b0);
      settle();
      chk_irq("R4 falling latched", 1'b1, 1'b0);
      wr_reg(1'b1, 1, 32'h0000_0100);
      #1 chk_irq("R4 cleared", 1'b0, 1'b0);

      // R5 level source 100 (group 3 bit 4)
      wr_reg(1'b0, 3, 32'hFFFF_FFEF);
      wr_reg(1'b0, 24, 32'h0000_0010);
      set_src(100, 1'b1);
      settle();
      chk_irq("R5 level asserted", 1'b1, 1'b0);
      wr_reg(1'b1, 3, 32'h0000_0010);
      @(negedge clk);
      chk_irq("R5 clear ignored", 1'b1, 1'b0);
      set_src(100, 1'b0);
      settle();
      chk_irq("R5 level released", 1'b0, 1'b0);

      // R8 disabled source keeps pending, source 150 (group 4 bit 22)
      set_src(150, 1'b1);
      settle();
      chk_irq("R8 disabled quiet", 1'b0, 1'b0);
      rd_reg(1'b1, 18, 32'h0, "R8 masked pending hidden");
      set_src(150, 1'b0);
      wr_reg(1'b0, 25, 32'h0040_0000);
      #1 chk_irq("R8 enable shows held pending", 1'b1, 1'b0);
      wr_reg(1'b1, 4, 32'h0040_0000);
      #1 chk_irq("R8 cleared", 1'b0, 1'b0);

      // R6 edge and clear on the same cycle: set wins
      set_src(5, 1'b1);
      @(posedge clk); @(posedge clk);
      wr_reg(1'b1, 0, 32'h0000_0020);
      #1 chk_irq("R6 set beats clear", 1'b1, 1'b0);
      wr_reg(1'b1, 0, 32'h0000_0020);
      #1 chk_irq("R6 clear after collision", 1'b0, 1'b0);
      set_src(5, 1'b0);

      // R12 read-only status words
      wr_reg(1'b1, 14, 32'hFFFF_FFFF);
      wr_reg(1'b1, 31, 32'hFFFF_FFFF);
      rd_reg(1'b1, 14, 32'h0, "R12 status write ignored");
      rd_reg(1'b1, 0,  32'h0, "R12 clear word reads zero");
      rd_reg(1'b1, 31, 32'h0, "R12 summary write ignored");

      // R2 configuration write/read
      wr_reg(1'b0, 12, 32'hA5A5_0000);
      rd_reg(1'b0, 12, 32'hA5A5_0000, "R2 polarity word group5");
      wr_reg(1'b0, 12, 32'h0);
      rd_reg(1'b0, 12, 32'h0,         "R2 polarity restored");
      rd_reg(1'b0, 27, 32'h0000_0100, "R2 enable word group6");
      rd_reg(1'b0, 20, 32'hFFFF_FEFF, "R2 routing word group6");
      settle();
      chk_irq("R7 idle at end", 1'b0, 1'b0);

      @(negedge clk);
      @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule